// File: doc/BRIEF.md
# Sliding-Window Covariance Averager

This block turns a stream of four-channel complex sample vectors into a running estimate of their spatial covariance. On every cycle where the input strobe is high it takes the vector x, forms every entry x_i * conj(x_j), and adds that matrix to a sum held over the most recent WIN accepted vectors. The same cycle, it removes the matrix of the vector that has just left the window. The sum is scaled by a plain arithmetic right shift of log2(WIN)/2 bits, which divides by sqrt(WIN) when WIN is a power of four. The result feeds a downstream solver that derives weights from it. Cycles without the strobe leave all state untouched.

A two-state controller sets when subtraction starts. State FILL holds from reset until WIN vectors have been accepted; there the expiring term is forced to zero, so the sum is simply the total since reset. The transition FILL to SLIDE fires on the accepted vector that fills the last delay slot. State SLIDE holds until the next reset and subtracts the expiring term on each accepted vector. The delay line stores raw sample vectors rather than products, and the expiring matrix is formed again when it is read back. Only the upper triangle (j >= i) is accumulated. In full mode the lower entries are mirrored from it, with the imaginary part negated before the shift.

Top module: `cov_window_avg`

## Requirements
- R1: `out_valid` is high in exactly the cycles that follow a clock edge where `in_valid` was high, and low after reset.
- R2: The sample of channel c sits at bits [c*SW +: SW] of `in_re` and `in_im`, as signed values. Entry (i,j) is the sum of x_i*conj(x_j): its real part is re_i*re_j + im_i*im_j and its imaginary part is im_i*re_j - re_i*im_j. In full mode, entry (i,j) sits at slot i*NCH+j of `out_re`/`out_im`, and each slot is OW bits wide.
- R3: Once more than WIN vectors have been accepted since reset, each entry covers exactly the last WIN accepted vectors, including the one just taken.
- R4: While WIN or fewer vectors have been accepted since reset, each entry covers every accepted vector since reset.
- R5: Each output slot equals floor(S / 2^(log2(WIN)/2)), where S is the exact window sum. OW = 2*SW+1+log2(WIN)/2 bits, and the shift is 5 for WIN = 1024.
- R6: A cycle with `in_valid` low changes no output value, whatever is on `in_re` and `in_im`.
- R7: Diagonal entries have a zero imaginary part and a non-negative real part.
- R8: In full mode, re(j,i) equals re(i,j), and im(i,j) + im(j,i) is 0, or -1 when the shift discards a non-zero remainder.
- R9: With UPPER_ONLY set, only the NCH*(NCH+1)/2 entries with j >= i are output, in row-major order: (0,0),(0,1),...,(0,NCH-1),(1,1),...,(NCH-1,NCH-1).
- R10: A synchronous reset empties the window. Outputs read zero, and no vector accepted before the reset is ever subtracted after it.
- R11: The accumulators are log2(WIN) bits wider than a product, so a window of full-scale negative samples does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input vector strobe |
| in_re | input | NCH*SW | Real parts, channel c at [c*SW +: SW] |
| in_im | input | NCH*SW | Imaginary parts, same layout |
| out_valid | output | 1 | Output update strobe |
| out_re | output | NOUT*OW | Scaled real parts of the entries |
| out_im | output | NOUT*OW | Scaled imaginary parts of the entries |

## Verification
Two configurations share one stimulus stream: a full 4x4 matrix with a 16-deep window, and an upper-triangle matrix with a 4-deep window. Every output slot is compared each cycle against window sums that the bench computes from its own sample history.

The stimulus patterns each target a different fault:
- A continuous pseudo-random run separates the fill phase from the sliding phase and catches an off-by-one in the expiry point.
- A run with strobe gaps and junk data on the idle cycles shows whether idle cycles leak into the state.
- A full-scale negative run exposes accumulator wrap and wrong scaling.
- A sweep over every real/imaginary pair on one channel, against fixed and moving neighbours, exposes sign and conjugation errors in the products.
- A reset issued mid-stream shows whether stale samples are later subtracted.

// File: rtl/cov_pkg.sv
package cov_pkg;

    // Window controller states: filling the delay line, then sliding.
    typedef enum logic {
        ST_FILL  = 1'b0,
        ST_SLIDE = 1'b1
    } win_state_t;

    // Number of matrix entries presented at the output.
    function automatic int ent_count(input int nch, input bit upper);
        return upper ? (nch * (nch + 1)) / 2 : nch * nch;
    endfunction

    // Slot of entry (i,j): row-major over j >= i when upper, else i*nch+j.
    function automatic int ent_index(input int i, input int j, input int nch, input bit upper);
        return upper ? (i * nch - (i * (i - 1)) / 2 + (j - i)) : (i * nch + j);
    endfunction

endpackage

// File: rtl/cov_fill_ctrl.sv
module cov_fill_ctrl
    import cov_pkg::*;
#(
    parameter int WIN = 1024,
    localparam int AW = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] slot,
    output logic          expire_en
);

    win_state_t    state_q;
    win_state_t    state_d;
    logic [AW-1:0] slot_q;
    logic          last_slot;

    assign last_slot = (slot_q == AW'(WIN - 1));

    // Next state: FILL -> SLIDE when the final slot is written.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL:  if (adv && last_slot) state_d = ST_SLIDE;
            ST_SLIDE: state_d = ST_SLIDE;
        endcase
    end

    // State and slot pointer registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            if (adv) slot_q <= slot_q + 1'b1;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        expire_en = 1'b0;
        unique case (state_q)
            ST_FILL:  expire_en = 1'b0;
            ST_SLIDE: expire_en = 1'b1;
        endcase
    end

    assign slot = slot_q;

endmodule

// File: rtl/cov_sample_delay.sv
module cov_sample_delay #(
    parameter int WIN = 1024,
    parameter int VW  = 128,
    localparam int AW = $clog2(WIN)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] slot,
    input  logic [VW-1:0] din,
    output logic [VW-1:0] dout
);

    logic [VW-1:0] mem [WIN];

    // Read the vector about to be overwritten; it is the one leaving the window.
    assign dout = mem[slot];

    always_ff @(posedge clk) begin
        if (wr_en) mem[slot] <= din;
    end

endmodule

// File: rtl/cov_outer_product.sv
module cov_outer_product
    import cov_pkg::*;
#(
    parameter int NCH = 4,
    parameter int SW  = 16,
    localparam int PW  = 2 * SW + 1,
    localparam int NUP = ent_count(NCH, 1'b1)
) (
    input  logic [NCH*SW-1:0] v_re,
    input  logic [NCH*SW-1:0] v_im,
    output logic [NUP*PW-1:0] p_re,
    output logic [NUP*PW-1:0] p_im
);

    for (genvar i = 0; i < NCH; i++) begin : g_row
        for (genvar j = i; j < NCH; j++) begin : g_col
            localparam int E = ent_index(i, j, NCH, 1'b1);
            logic signed [PW-1:0] ar, ai, br, bi;
            assign ar = PW'($signed(v_re[i*SW +: SW]));
            assign ai = PW'($signed(v_im[i*SW +: SW]));
            assign br = PW'($signed(v_re[j*SW +: SW]));
            assign bi = PW'($signed(v_im[j*SW +: SW]));
            // x_i * conj(x_j)
            assign p_re[E*PW +: PW] = ar * br + ai * bi;
            assign p_im[E*PW +: PW] = ai * br - ar * bi;
        end
    end

endmodule

// File: rtl/cov_entry_acc.sv
module cov_entry_acc #(
    parameter int PW   = 33,
    parameter int ACCW = 43
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            sub_en,
    input  logic [PW-1:0]   add_re,
    input  logic [PW-1:0]   add_im,
    input  logic [PW-1:0]   sub_re,
    input  logic [PW-1:0]   sub_im,
    output logic [ACCW-1:0] acc_re,
    output logic [ACCW-1:0] acc_im
);

    logic signed [ACCW-1:0] inc_re, inc_im, dec_re, dec_im;

    assign inc_re = ACCW'($signed(add_re));
    assign inc_im = ACCW'($signed(add_im));
    assign dec_re = sub_en ? ACCW'($signed(sub_re)) : '0;
    assign dec_im = sub_en ? ACCW'($signed(sub_im)) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_re <= '0;
            acc_im <= '0;
        end else if (en) begin
            acc_re <= acc_re + inc_re - dec_re;
            acc_im <= acc_im + inc_im - dec_im;
        end
    end

endmodule

// File: rtl/cov_window_avg.sv
module cov_window_avg
    import cov_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int SW         = 16,
    parameter int WIN        = 1024,
    parameter bit UPPER_ONLY = 1'b0,
    localparam int LOG2W = $clog2(WIN),
    localparam int SHIFT = LOG2W / 2,
    localparam int PW    = 2 * SW + 1,
    localparam int ACCW  = PW + LOG2W,
    localparam int OW    = ACCW - SHIFT,
    localparam int NUP   = ent_count(NCH, 1'b1),
    localparam int NOUT  = ent_count(NCH, UPPER_ONLY),
    localparam int VW    = 2 * NCH * SW,
    localparam int AW    = $clog2(WIN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [NCH*SW-1:0] in_re,
    input  logic [NCH*SW-1:0] in_im,
    output logic              out_valid,
    output logic [NOUT*OW-1:0] out_re,
    output logic [NOUT*OW-1:0] out_im
);

    logic [AW-1:0]       slot;
    logic                expire_en;
    logic [VW-1:0]       old_vec;
    logic [NUP*PW-1:0]   new_p_re, new_p_im, old_p_re, old_p_im;
    logic [NUP*ACCW-1:0] acc_re, acc_im;

    cov_fill_ctrl #(.WIN(WIN)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .adv       (in_valid),
        .slot      (slot),
        .expire_en (expire_en)
    );

    cov_sample_delay #(.WIN(WIN), .VW(VW)) u_delay (
        .clk   (clk),
        .wr_en (in_valid),
        .slot  (slot),
        .din   ({in_im, in_re}),
        .dout  (old_vec)
    );

    cov_outer_product #(.NCH(NCH), .SW(SW)) u_new_prod (
        .v_re (in_re),
        .v_im (in_im),
        .p_re (new_p_re),
        .p_im (new_p_im)
    );

    cov_outer_product #(.NCH(NCH), .SW(SW)) u_old_prod (
        .v_re (old_vec[NCH*SW-1:0]),
        .v_im (old_vec[VW-1:NCH*SW]),
        .p_re (old_p_re),
        .p_im (old_p_im)
    );

    for (genvar e = 0; e < NUP; e++) begin : g_acc
        cov_entry_acc #(.PW(PW), .ACCW(ACCW)) u_acc (
            .clk    (clk),
            .rst    (rst),
            .en     (in_valid),
            .sub_en (expire_en),
            .add_re (new_p_re[e*PW +: PW]),
            .add_im (new_p_im[e*PW +: PW]),
            .sub_re (old_p_re[e*PW +: PW]),
            .sub_im (old_p_im[e*PW +: PW]),
            .acc_re (acc_re[e*ACCW +: ACCW]),
            .acc_im (acc_im[e*ACCW +: ACCW])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    // Output mapping: scaled upper entries, mirrored lower entries in full mode.
    for (genvar i = 0; i < NCH; i++) begin : g_orow
        for (genvar j = 0; j < NCH; j++) begin : g_ocol
            if (j >= i) begin : g_up
                localparam int S = ent_index(i, j, NCH, 1'b1);
                localparam int D = ent_index(i, j, NCH, UPPER_ONLY);
                assign out_re[D*OW +: OW] = acc_re[S*ACCW+SHIFT +: OW];
                assign out_im[D*OW +: OW] = acc_im[S*ACCW+SHIFT +: OW];
            end else if (!UPPER_ONLY) begin : g_lo
                localparam int S = ent_index(j, i, NCH, 1'b1);
                localparam int D = ent_index(i, j, NCH, 1'b0);
                logic [ACCW-1:0] neg_im;
                assign neg_im = -acc_im[S*ACCW +: ACCW];
                assign out_re[D*OW +: OW] = acc_re[S*ACCW+SHIFT +: OW];
                assign out_im[D*OW +: OW] = neg_im[ACCW-1:SHIFT];
            end
        end
    end

endmodule

// File: rtl/cov_window_avg_chk.sv
module cov_window_avg_chk
    import cov_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int SW         = 16,
    parameter int WIN        = 1024,
    parameter bit UPPER_ONLY = 1'b0,
    localparam int LOG2W = $clog2(WIN),
    localparam int OW    = 2 * SW + 1 + LOG2W - LOG2W / 2,
    localparam int NOUT  = ent_count(NCH, UPPER_ONLY),
    localparam int OW1   = OW + 1
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [NOUT*OW-1:0] out_re,
    input logic [NOUT*OW-1:0] out_im
);

    assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_re) && $stable(out_im)));

    for (genvar c = 0; c < NCH; c++) begin : g_diag
        localparam int D = ent_index(c, c, NCH, UPPER_ONLY);
        assert_diag_real_R7: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> (out_im[D*OW +: OW] == '0 && !out_re[D*OW+OW-1]));
    end

    if (!UPPER_ONLY) begin : g_sym
        for (genvar i = 0; i < NCH; i++) begin : g_i
            for (genvar j = i + 1; j < NCH; j++) begin : g_j
                localparam int EU = ent_index(i, j, NCH, 1'b0);
                localparam int EL = ent_index(j, i, NCH, 1'b0);
                logic signed [OW:0] im_sum;
                assign im_sum = OW1'($signed(out_im[EU*OW +: OW])) + OW1'($signed(out_im[EL*OW +: OW]));
                assert_hermitian_R8: assert property (@(posedge clk) disable iff (rst)
                    out_valid |-> (out_re[EU*OW +: OW] == out_re[EL*OW +: OW]
                                   && (im_sum == 0 || im_sum == -1)));
            end
        end
    end

endmodule

bind cov_window_avg cov_window_avg_chk #(
    .NCH(NCH), .SW(SW), .WIN(WIN), .UPPER_ONLY(UPPER_ONLY)
) u_chk (.*);

// File: tb/cov_window_avg_bench.sv
module cov_window_avg_bench;

    localparam int NCH = 4;
    localparam int SW  = 4;
    // Configuration A: full matrix, window 16, shift 2, slot width 11
    localparam int WA = 16, SA = 2, OWA = 11, NA = 16;
    // Configuration B: upper triangle, window 4, shift 1, slot width 10
    localparam int WB = 4, SB = 1, OWB = 10, NB = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [NCH*SW-1:0] in_re = '0, in_im = '0;
    logic va, vb;
    logic [NA*OWA-1:0] ra, ia;
    logic [NB*OWB-1:0] rb, ib;

    always #2 clk = ~clk;

    cov_window_avg #(.NCH(NCH), .SW(SW), .WIN(WA), .UPPER_ONLY(1'b0)) u_cov_window_avg (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(va), .out_re(ra), .out_im(ia));

    cov_window_avg #(.NCH(NCH), .SW(SW), .WIN(WB), .UPPER_ONLY(1'b1)) u_cov_window_avg_upper (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
        .out_valid(vb), .out_re(rb), .out_im(ib));

    int n_chk = 0, n_fail = 0;
    int hist_re [0:1023][NCH];
    int hist_im [0:1023][NCH];
    int n_hist = 0;
    bit last_v = 1'b0;
    string phase = "reset";
    int unsigned seed = 32'h1234_5679;
    int cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 200000 && !done) begin
            n_chk  = n_chk + 1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog: cycles %0d expected below %0d", cyc, 200000);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0d expected %0d", req, phase, what, act, exp);
        end
    endtask

    function automatic int sx(input logic [255:0] v, input int e, input int ow);
        logic [255:0] t;
        int r;
        t = v >> (e * ow);
        r = 0;
        for (int b = 0; b < ow; b++) if (t[b]) r = r | (1 << b);
        if (t[ow-1]) r = r - (1 << ow);
        return r;
    endfunction

    // Exact window sum of x_i*conj(x_j) over the last w accepted vectors (R2 R3 R4)
    function automatic int ref_sum(input int i, input int j, input bit im, input int w);
        int s, lo;
        s = 0;
        lo = (n_hist > w) ? n_hist - w : 0;
        for (int k = lo; k < n_hist; k++)
            s += im ? (hist_im[k][i] * hist_re[k][j] - hist_re[k][i] * hist_im[k][j])
                    : (hist_re[k][i] * hist_re[k][j] + hist_im[k][i] * hist_im[k][j]);
        return s;
    endfunction

    task automatic do_check();
        string vt, tag;
        int bad_a, act_a, exp_a, bad_b, act_b, exp_b, diag_bad, sym_bad;
        vt = last_v ? "R1" : "R6";
        check_eq(vt, "config A out_valid", int'(va), int'(last_v));
        check_eq(vt, "config B out_valid", int'(vb), int'(last_v));
        tag = !last_v ? "R6" : ((n_hist > WA) ? "R3" : "R4");
        // Config A: full mode, slot i*4+j, scaled by >>> 2 (R2 R5)
        bad_a = 0; act_a = 0; exp_a = 0;
        for (int i = 0; i < NCH; i++)
            for (int j = 0; j < NCH; j++)
                for (int p = 0; p < 2; p++) begin
                    int a, x;
                    a = (p == 0) ? sx(ra, i*NCH+j, OWA) : sx(ia, i*NCH+j, OWA);
                    x = ref_sum(i, j, p[0], WA) >>> SA;
                    if (a != x && bad_a == 0) begin bad_a = 1; act_a = a; exp_a = x; end
                end
        check_eq({tag, " R2 R5"}, "config A entry value", act_a, exp_a);
        // Config B: upper triangle row-major, scaled by >>> 1 (R9)
        bad_b = 0; act_b = 0; exp_b = 0;
        begin
            int e;
            e = 0;
            for (int i = 0; i < NCH; i++)
                for (int j = i; j < NCH; j++) begin
                    for (int p = 0; p < 2; p++) begin
                        int a, x;
                        a = (p == 0) ? sx(rb, e, OWB) : sx(ib, e, OWB);
                        x = ref_sum(i, j, p[0], WB) >>> SB;
                        if (a != x && bad_b == 0) begin bad_b = 1; act_b = a; exp_b = x; end
                    end
                    e++;
                end
        end
        check_eq({tag, " R9"}, "config B upper entry value", act_b, exp_b);
        // R7: diagonal real and non-negative
        diag_bad = 0;
        for (int c = 0; c < NCH; c++)
            if (sx(ia, c*NCH+c, OWA) != 0 || sx(ra, c*NCH+c, OWA) < 0) diag_bad++;
        check_eq("R7", "diagonal entries not real non-negative", diag_bad, 0);
        // R8: mirrored entries
        sym_bad = 0;
        for (int i = 0; i < NCH; i++)
            for (int j = i + 1; j < NCH; j++) begin
                int s;
                s = sx(ia, i*NCH+j, OWA) + sx(ia, j*NCH+i, OWA);
                if (sx(ra, i*NCH+j, OWA) != sx(ra, j*NCH+i, OWA) || (s != 0 && s != -1)) sym_bad++;
            end
        check_eq("R8", "asymmetric entry pairs", sym_bad, 0);
    endtask

    task automatic drive(input bit v, input int re[NCH], input int im[NCH]);
        @(negedge clk);
        do_check();
        in_valid = v;
        for (int c = 0; c < NCH; c++) begin
            in_re[c*SW +: SW] = SW'(re[c]);
            in_im[c*SW +: SW] = SW'(im[c]);
        end
        if (v) begin
            for (int c = 0; c < NCH; c++) begin
                hist_re[n_hist][c] = re[c];
                hist_im[n_hist][c] = im[c];
            end
            n_hist++;
        end
        last_v = v;
    endtask

    task automatic reset_check();
        check_eq("R10", "config A out_valid after reset", int'(va), 0);
        check_eq("R10", "config B out_valid after reset", int'(vb), 0);
        check_eq("R10", "config A nonzero outputs after reset", int'((|ra) || (|ia)), 0);
        check_eq("R10", "config B nonzero outputs after reset", int'((|rb) || (|ib)), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        do_check();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        n_hist = 0;
        last_v = 1'b0;
        @(negedge clk);
        reset_check();
    endtask

    function automatic int rnd4();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return int'(seed & 32'hF) - 8;
    endfunction

    initial begin
        int r[NCH];
        int m[NCH];
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reset_check();

        phase = "continuous random, fill then slide";
        for (int t = 0; t < 40; t++) begin
            for (int c = 0; c < NCH; c++) begin r[c] = rnd4(); m[c] = rnd4(); end
            drive(1'b1, r, m);
        end

        phase = "R6 gaps with junk on idle cycles";
        for (int t = 0; t < 45; t++) begin
            for (int c = 0; c < NCH; c++) begin r[c] = rnd4(); m[c] = rnd4(); end
            drive((t % 3) != 2, r, m);
        end

        phase = "R11 full-scale negative";
        for (int c = 0; c < NCH; c++) begin r[c] = -8; m[c] = -8; end
        for (int t = 0; t < 20; t++) drive(1'b1, r, m);
        drive(1'b0, r, m);
        // Every product is 128; A: 16*128 >>> 2, B: 4*128 >>> 1
        check_eq("R11", "config A full-scale entry (1,2)", sx(ra, 1*NCH+2, OWA), 512);
        check_eq("R11", "config B full-scale entry (0,0)", sx(rb, 0, OWB), 256);

        phase = "R2 sweep of channel 0 over all values";
        for (int a = 0; a < 256; a++) begin
            r[0] = (a >> 4) - 8;
            m[0] = (a & 15) - 8;
            r[1] = -m[0] - 1;
            m[1] = r[0];
            r[2] = 7;
            m[2] = -8;
            r[3] = ((a * 5) & 15) - 8;
            m[3] = ((a * 3) & 15) - 8;
            drive(1'b1, r, m);
        end

        phase = "R10 reset mid-stream";
        do_reset();
        for (int t = 0; t < 30; t++) begin
            for (int c = 0; c < NCH; c++) begin r[c] = rnd4(); m[c] = rnd4(); end
            drive((t % 5) != 4, r, m);
        end
        drive(1'b0, r, m);
        @(negedge clk);
        do_check();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule